// File: doc/BRIEF.md
# DMA descriptor command decoder

The block receives one 16-byte command descriptor at a time from a descriptor fetcher and turns it into a single action. The action is a data transfer request (input or output, optionally marked as the last of a chain), a single-word load or store request, an immediate no-operation completion, or a stop. When the descriptor carries an illegal encoding, the block kills the channel instead of acting. Moving the data, performing bus cycles and evaluating wait, branch or interrupt conditions all belong to neighbouring logic. The transfer side reports the end of a request through a done strobe that carries the residual count and, for loads, the word that was read.

The block holds the channel's command pointer and its ACTIVE, DEAD and FLUSH flags. A software-facing neighbour drives RUN as a level and pulses wake and flush requests. On every completed command the block presents a write-back record for the descriptor: the residual count, a status snapshot and the dependent word. It then advances the command pointer by one descriptor so that the fetcher can load the next one.

Top module: `dma_cmd_dispatch`

## Requirements
- R1: After reset the command pointer is 0 and ACTIVE, DEAD, FLUSH, busy, both request strobes, the write-back strobe and the interrupt are all 0.
- R2: A held descriptor is dispatched only when RUN is 1, ACTIVE is 1 and no request is outstanding. The request strobe (xfer_req_o or word_req_o) is high for exactly the one cycle after the dispatching clock edge. A descriptor presented while the channel is inactive waits without producing any request until a wake makes the channel active.
- R3: The command code is command bits 15:12. Codes 0 to 3 are transfers: 0 is output, 1 is output-last, 2 is input and 3 is input-last. A transfer drives xfer_req_o with req_addr_o set to the descriptor address and req_len_o set to the request count. req_write_o is 1 for the output codes, and req_last_o is 1 for codes 1 and 3.
- R4: The key is command bits 10:8. A transfer whose key is 4 to 7, or whose data address is zero, kills the channel and issues no request.
- R5: Code 4 is store word and code 5 is load word. Only request-count bits 2:0 are used. If bit 2 is set, the length is 4 and address bits 1:0 are cleared. Otherwise, if bit 1 is set, the length is 2 and address bit 0 is cleared. Otherwise the length is 1 and the address is passed unchanged. req_write_o is 1 for store, and req_data_o carries the descriptor's dependent word.
- R6: Word commands accept keys 0 to 3 and the system key 6. Keys 4, 5 and 7 kill the channel.
- R7: Codes 8 to 15 kill the channel. A kill sets DEAD, clears ACTIVE, pulses irq_o for one cycle, leaves the command pointer unchanged and produces no write-back.
- R8: Code 7 (stop) clears ACTIVE, leaves the command pointer and the held descriptor unchanged, and produces no write-back. A later wake re-executes the same stop.
- R9: done_i while busy ends the request. In the next cycle wb_valid_o pulses and the command pointer has advanced by 16. wb_res_o is done_res_i for a transfer and 0 for word commands. wb_dep_o is done_data_i for a load and the descriptor's dependent word otherwise. wb_status_o is the status at completion, with RUN in bit 15, FLUSH in bit 13, DEAD in bit 11, ACTIVE in bit 10 and 0 elsewhere.
- R10: A completing word command or last-transfer clears FLUSH, after its status snapshot has been taken. A completing code 0 or 2 transfer leaves FLUSH set, and so does a no-operation.
- R11: Code 6 (no-operation) issues no request. It completes at its dispatching edge, with a write-back of residual 0 and the pointer advanced by 16, and it never kills, whatever its key.
- R12: A command-pointer write is ignored while ACTIVE is 1. Otherwise it loads the written value with bits 3:0 forced to 0.
- R13: RUN low clears ACTIVE and DEAD. A wake pulse while RUN is high sets ACTIVE. A kill or stop at the same edge takes priority over the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Channel run level |
| wake_i | input | 1 | Wake pulse, activates a running channel |
| flush_i | input | 1 | Flush request pulse, sets FLUSH |
| ptr_wr_i | input | 1 | Command pointer write strobe |
| ptr_wdata_i | input | 32 | Command pointer write value |
| desc_valid_i | input | 1 | Fetched descriptor strobe, accepted when not busy |
| desc_count_i | input | 16 | Descriptor request count |
| desc_cmd_i | input | 16 | Descriptor command word |
| desc_addr_i | input | 32 | Descriptor data address |
| desc_dep_i | input | 32 | Descriptor dependent word |
| done_i | input | 1 | Request completion strobe |
| done_res_i | input | 16 | Residual count reported at completion |
| done_data_i | input | 32 | Word read by a load |
| xfer_req_o | output | 1 | Transfer request strobe |
| word_req_o | output | 1 | Word load/store request strobe |
| req_write_o | output | 1 | Request direction, 1 = towards the device or memory write |
| req_last_o | output | 1 | Transfer is the last of a chain |
| req_addr_o | output | 32 | Request address (normalised for word commands) |
| req_len_o | output | 16 | Request length in bytes |
| req_data_o | output | 32 | Store data (dependent word) |
| busy_o | output | 1 | A request is outstanding |
| wb_valid_o | output | 1 | Descriptor write-back strobe |
| wb_res_o | output | 16 | Residual count to write back |
| wb_status_o | output | 16 | Status snapshot to write back |
| wb_dep_o | output | 32 | Dependent word to write back |
| cmd_ptr_o | output | 32 | Command pointer |
| active_o | output | 1 | ACTIVE flag |
| dead_o | output | 1 | DEAD flag |
| flush_o | output | 1 | FLUSH flag |
| irq_o | output | 1 | One-cycle interrupt pulse on a kill |

## Verification
A wrong held descriptor or a stale busy flag shows up in the cycle after the dispatching edge: a request strobe that is missing, duplicated or carries the wrong address, length or direction. A kill or stop that moves the pointer, or a completion that fails to move it, appears on cmd_ptr_o one cycle after the event. A flag updated in the wrong order appears in the wb_status_o snapshot and in flush_o in the cycle after completion. The behavioural model is compared against every output on every clock, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/dma_cmd_dispatch.sv
module dma_cmd_dispatch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic        wake_i,
  input  logic        flush_i,
  input  logic        ptr_wr_i,
  input  logic [31:0] ptr_wdata_i,
  input  logic        desc_valid_i,
  input  logic [15:0] desc_count_i,
  input  logic [15:0] desc_cmd_i,
  input  logic [31:0] desc_addr_i,
  input  logic [31:0] desc_dep_i,
  input  logic        done_i,
  input  logic [15:0] done_res_i,
  input  logic [31:0] done_data_i,
  output logic        xfer_req_o,
  output logic        word_req_o,
  output logic        req_write_o,
  output logic        req_last_o,
  output logic [31:0] req_addr_o,
  output logic [15:0] req_len_o,
  output logic [31:0] req_data_o,
  output logic        busy_o,
  output logic        wb_valid_o,
  output logic [15:0] wb_res_o,
  output logic [15:0] wb_status_o,
  output logic [31:0] wb_dep_o,
  output logic [31:0] cmd_ptr_o,
  output logic        active_o,
  output logic        dead_o,
  output logic        flush_o,
  output logic        irq_o
);

  localparam logic [31:0] DESC_STEP = 32'd16;
  localparam logic [2:0]  SYS_KEY   = 3'd6;

  logic        have_q, busy_q, load_q, word_q, clrflush_q;
  logic [15:0] cnt_q;
  logic [3:0]  op_q;
  logic [2:0]  key_q;
  logic [31:0] addr_q, dep_q;

  logic unused_bits;
  assign unused_bits = ^{desc_cmd_i[11], desc_cmd_i[7:0]};

  wire go        = have_q & run_i & active_o & ~busy_q;
  wire is_xfer   = (op_q[3:2] == 2'b00);
  wire is_word   = (op_q[3:1] == 3'b010);
  wire is_nop    = (op_q == 4'd6);
  wire is_stop   = (op_q == 4'd7);
  wire word_key  = ~key_q[2] | (key_q == SYS_KEY);
  wire kill      = op_q[3] | (is_xfer & (key_q[2] | (addr_q == 32'd0))) | (is_word & ~word_key);

  wire [15:0] wlen  = cnt_q[2] ? 16'd4 : (cnt_q[1] ? 16'd2 : 16'd1);
  wire [31:0] waddr = cnt_q[2] ? {addr_q[31:2], 2'b00} :
                      (cnt_q[1] ? {addr_q[31:1], 1'b0} : addr_q);
  wire [15:0] status = {run_i, 1'b0, flush_o, 1'b0, dead_o, active_o, 10'd0};

  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0; busy_q <= 1'b0; load_q <= 1'b0; word_q <= 1'b0; clrflush_q <= 1'b0;
      cnt_q <= '0; op_q <= '0; key_q <= '0; addr_q <= '0; dep_q <= '0;
      xfer_req_o <= 1'b0; word_req_o <= 1'b0; req_write_o <= 1'b0; req_last_o <= 1'b0;
      req_addr_o <= '0; req_len_o <= '0; req_data_o <= '0;
      wb_valid_o <= 1'b0; wb_res_o <= '0; wb_status_o <= '0; wb_dep_o <= '0;
      cmd_ptr_o <= '0; active_o <= 1'b0; dead_o <= 1'b0; flush_o <= 1'b0; irq_o <= 1'b0;
    end else begin
      xfer_req_o <= 1'b0;
      word_req_o <= 1'b0;
      wb_valid_o <= 1'b0;
      irq_o      <= 1'b0;

      if (desc_valid_i && !busy_q) begin
        have_q <= 1'b1;
        cnt_q  <= desc_count_i;
        op_q   <= desc_cmd_i[15:12];
        key_q  <= desc_cmd_i[10:8];
        addr_q <= desc_addr_i;
        dep_q  <= desc_dep_i;
      end

      if (ptr_wr_i && !active_o)
        cmd_ptr_o <= {ptr_wdata_i[31:4], 4'b0000};

      if (flush_i)
        flush_o <= 1'b1;

      if (!run_i) begin
        active_o <= 1'b0;
        dead_o   <= 1'b0;
      end else if (wake_i) begin
        active_o <= 1'b1;
      end

      if (go) begin
        if (kill) begin
          dead_o   <= 1'b1;
          active_o <= 1'b0;
          irq_o    <= 1'b1;
        end else if (is_stop) begin
          active_o <= 1'b0;
        end else if (is_nop) begin
          wb_valid_o  <= 1'b1;
          wb_res_o    <= '0;
          wb_status_o <= status;
          wb_dep_o    <= dep_q;
          cmd_ptr_o   <= cmd_ptr_o + DESC_STEP;
          have_q      <= 1'b0;
        end else begin
          busy_q      <= 1'b1;
          xfer_req_o  <= is_xfer;
          word_req_o  <= is_word;
          req_write_o <= is_xfer ? ~op_q[1] : ~op_q[0];
          req_last_o  <= is_xfer & op_q[0];
          req_addr_o  <= is_xfer ? addr_q : waddr;
          req_len_o   <= is_xfer ? cnt_q : wlen;
          req_data_o  <= dep_q;
          load_q      <= is_word & op_q[0];
          word_q      <= is_word;
          clrflush_q  <= is_word | op_q[0];
        end
      end

      if (busy_q && done_i) begin
        busy_q      <= 1'b0;
        wb_valid_o  <= 1'b1;
        wb_res_o    <= word_q ? 16'd0 : done_res_i;
        wb_status_o <= status;
        wb_dep_o    <= load_q ? done_data_i : req_data_o;
        cmd_ptr_o   <= cmd_ptr_o + DESC_STEP;
        have_q      <= 1'b0;
        if (clrflush_q)
          flush_o <= 1'b0;
      end
    end
  end

  // R12
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr_o[3:0] == 4'b0000);

  // R7
  kill_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dead_o) |-> (irq_o && !active_o && !wb_valid_o));

  // R7
  kill_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && kill) |=> $stable(cmd_ptr_o));

  // R8
  stop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !kill && is_stop) |=> ($stable(cmd_ptr_o) && !active_o && !wb_valid_o));

  // R5
  word_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_req_o |-> ((req_len_o == 16'd4 && req_addr_o[1:0] == 2'b00) ||
                    (req_len_o == 16'd2 && req_addr_o[0] == 1'b0) ||
                    (req_len_o == 16'd1)));

  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_req_o && word_req_o));

  // R2
  dispatch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(active_o && run_i));

  // R9
  wb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> !busy_o);

endmodule

// File: tb/dma_cmd_dispatch_test.sv
`timescale 1ns/100ps
module dma_cmd_dispatch_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, run_i = 1'b0, wake_i = 1'b0, flush_i = 1'b0, ptr_wr_i = 1'b0;
  logic [31:0] ptr_wdata_i = '0;
  logic        desc_valid_i = 1'b0;
  logic [15:0] desc_count_i = '0, desc_cmd_i = '0;
  logic [31:0] desc_addr_i = '0, desc_dep_i = '0;
  logic        done_i = 1'b0;
  logic [15:0] done_res_i = '0;
  logic [31:0] done_data_i = '0;

  logic        xfer_req_o, word_req_o, req_write_o, req_last_o, busy_o, wb_valid_o;
  logic [31:0] req_addr_o, req_data_o, wb_dep_o, cmd_ptr_o;
  logic [15:0] req_len_o, wb_res_o, wb_status_o;
  logic        active_o, dead_o, flush_o, irq_o;

  dma_cmd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .wake_i(wake_i), .flush_i(flush_i),
    .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i), .desc_valid_i(desc_valid_i),
    .desc_count_i(desc_count_i), .desc_cmd_i(desc_cmd_i), .desc_addr_i(desc_addr_i),
    .desc_dep_i(desc_dep_i), .done_i(done_i), .done_res_i(done_res_i), .done_data_i(done_data_i),
    .xfer_req_o(xfer_req_o), .word_req_o(word_req_o), .req_write_o(req_write_o),
    .req_last_o(req_last_o), .req_addr_o(req_addr_o), .req_len_o(req_len_o),
    .req_data_o(req_data_o), .busy_o(busy_o), .wb_valid_o(wb_valid_o), .wb_res_o(wb_res_o),
    .wb_status_o(wb_status_o), .wb_dep_o(wb_dep_o), .cmd_ptr_o(cmd_ptr_o),
    .active_o(active_o), .dead_o(dead_o), .flush_o(flush_o), .irq_o(irq_o)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ptr, m_addr, m_len, m_data, m_res, m_stat, m_dep;
  bit m_have, m_busy, m_active, m_dead, m_flush, m_xreq, m_wreq, m_write, m_last, m_wbv, m_irq;
  bit m_load, m_word, m_clr;
  int d_cnt, d_op, d_key, d_addr, d_dep;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_addr = 0; m_len = 0; m_data = 0; m_res = 0; m_stat = 0; m_dep = 0;
      m_have = 0; m_busy = 0; m_active = 0; m_dead = 0; m_flush = 0; m_xreq = 0; m_wreq = 0;
      m_write = 0; m_last = 0; m_wbv = 0; m_irq = 0; m_load = 0; m_word = 0; m_clr = 0;
      d_cnt = 0; d_op = 0; d_key = 0; d_addr = 0; d_dep = 0;
    end else begin
      int op, key, cnt, addr, dep, stat;
      bit busy0, active0, have0, go, legal;
      op = d_op; key = d_key; cnt = d_cnt; addr = d_addr; dep = d_dep;
      busy0 = m_busy; active0 = m_active; have0 = m_have;
      stat = (int'(run_i) << 15) | (int'(m_flush) << 13) | (int'(m_dead) << 11) | (int'(m_active) << 10);
      m_xreq = 0; m_wreq = 0; m_wbv = 0; m_irq = 0;
      if (desc_valid_i && !busy0) begin
        m_have = 1; d_cnt = desc_count_i; d_op = desc_cmd_i[15:12]; d_key = desc_cmd_i[10:8];
        d_addr = desc_addr_i; d_dep = desc_dep_i;
      end
      if (ptr_wr_i && !active0) m_ptr = ptr_wdata_i & 32'hFFFF_FFF0;
      if (flush_i) m_flush = 1;
      if (!run_i) begin m_active = 0; m_dead = 0; end
      else if (wake_i) m_active = 1;
      go = have0 && run_i && active0 && !busy0;
      if (go) begin
        if (op <= 3) legal = (key < 4) && (addr != 0);
        else if (op == 4 || op == 5) legal = (key < 4) || (key == 6);
        else legal = (op <= 7);
        if (!legal) begin
          m_dead = 1; m_active = 0; m_irq = 1;
        end else if (op == 7) begin
          m_active = 0;
        end else if (op == 6) begin
          m_wbv = 1; m_res = 0; m_stat = stat; m_dep = dep; m_ptr = m_ptr + 16; m_have = 0;
        end else begin
          m_busy = 1; m_data = dep;
          if (op <= 3) begin
            m_xreq = 1; m_addr = addr; m_len = cnt; m_write = (op <= 1); m_last = (op == 1 || op == 3);
            m_load = 0; m_word = 0; m_clr = m_last;
          end else begin
            m_wreq = 1; m_write = (op == 4); m_last = 0; m_load = (op == 5); m_word = 1; m_clr = 1;
            if (cnt & 4) begin m_len = 4; m_addr = addr & ~3; end
            else if (cnt & 2) begin m_len = 2; m_addr = addr & ~1; end
            else begin m_len = 1; m_addr = addr; end
          end
        end
      end
      if (busy0 && done_i) begin
        m_busy = 0; m_wbv = 1; m_stat = stat;
        m_res = m_word ? 0 : int'(done_res_i);
        m_dep = m_load ? int'(done_data_i) : m_data;
        m_ptr = m_ptr + 16; m_have = 0;
        if (m_clr) m_flush = 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if ({xfer_req_o, word_req_o, irq_o, wb_valid_o, busy_o, active_o, dead_o, flush_o} !==
          {m_xreq, m_wreq, m_irq, m_wbv, m_busy, m_active, m_dead, m_flush} ||
          cmd_ptr_o !== m_ptr[31:0] ||
          ((xfer_req_o || word_req_o) && ({req_addr_o, req_len_o, req_data_o, req_write_o, req_last_o} !==
            {m_addr[31:0], m_len[15:0], m_data[31:0], m_write, m_last})) ||
          (wb_valid_o && ({wb_res_o, wb_status_o, wb_dep_o} !== {m_res[15:0], m_stat[15:0], m_dep[31:0]}))) begin
        errors++;
        $display("FAIL R2/R9 model cycle %0d actual ptr=%h flags=%b expected ptr=%h flags=%b", cycles,
                 cmd_ptr_o, {xfer_req_o, word_req_o, irq_o, wb_valid_o, busy_o, active_o, dead_o, flush_o},
                 m_ptr, {m_xreq, m_wreq, m_irq, m_wbv, m_busy, m_active, m_dead, m_flush});
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic send_desc(logic [15:0] cnt, logic [15:0] cmd, logic [31:0] addr, logic [31:0] dep);
    desc_count_i = cnt; desc_cmd_i = cmd; desc_addr_i = addr; desc_dep_i = dep;
    desc_valid_i = 1'b1; tick(); desc_valid_i = 1'b0;
  endtask

  task automatic wake(); wake_i = 1'b1; tick(); wake_i = 1'b0; endtask
  task automatic flush(); flush_i = 1'b1; tick(); flush_i = 1'b0; endtask
  task automatic recover(); run_i = 1'b0; tick(); run_i = 1'b1; endtask

  task automatic run_cmd(logic [15:0] cnt, logic [15:0] cmd, logic [31:0] addr, logic [31:0] dep);
    send_desc(cnt, cmd, addr, dep);
    if (!active_o) wake();
    tick();
  endtask

  task automatic complete(logic [15:0] res, logic [31:0] data);
    done_res_i = res; done_data_i = data; done_i = 1'b1; tick(); done_i = 1'b0;
  endtask

  task automatic expect_kill(string req, logic [31:0] ptr);
    check(req, {31'd0, dead_o}, 32'd1);
    check(req, {31'd0, irq_o}, 32'd1);
    check(req, {31'd0, active_o}, 32'd0);
    check(req, cmd_ptr_o, ptr);
    tick();
    check({req, " irq pulse"}, {31'd0, irq_o}, 32'd0);
    recover();
  endtask

  initial begin
    bit saw;
    tick(); tick(); tick();
    // R1
    check("R1 ptr", cmd_ptr_o, 32'd0);
    check("R1 flags", {24'd0, xfer_req_o, word_req_o, wb_valid_o, busy_o, active_o, dead_o, flush_o, irq_o}, 32'd0);
    rst_n = 1'b1;

    ptr_wr_i = 1'b1; ptr_wdata_i = 32'h0001_2349; tick(); ptr_wr_i = 1'b0;
    check("R12 aligned load", cmd_ptr_o, 32'h0001_2340);
    run_i = 1'b1; wake();
    check("R13 wake", {31'd0, active_o}, 32'd1);
    ptr_wr_i = 1'b1; ptr_wdata_i = 32'h0000_0100; tick(); ptr_wr_i = 1'b0;
    check("R12 ignored when active", cmd_ptr_o, 32'h0001_2340);

    flush();
    run_cmd(16'h0040, 16'h0000, 32'h0000_1000, 32'h0);
    check("R3 out more req", {30'd0, xfer_req_o, word_req_o}, 32'd2);
    check("R3 out more dir/last", {30'd0, req_write_o, req_last_o}, 32'd2);
    check("R3 addr", req_addr_o, 32'h0000_1000);
    check("R3 len", {16'd0, req_len_o}, 32'h40);
    complete(16'h0010, 32'h0);
    check("R9 wb valid", {31'd0, wb_valid_o}, 32'd1);
    check("R9 residual", {16'd0, wb_res_o}, 32'h10);
    check("R9 status", {16'd0, wb_status_o}, 32'hA400);
    check("R9 ptr advance", cmd_ptr_o, 32'h0001_2350);
    check("R10 flush kept", {31'd0, flush_o}, 32'd1);

    run_cmd(16'h0008, 16'h1000, 32'h0000_1100, 32'h0);
    check("R3 out last dir/last", {30'd0, req_write_o, req_last_o}, 32'd3);
    complete(16'h0, 32'h0);
    check("R10 snapshot before clear", {16'd0, wb_status_o}, 32'hA400);
    check("R10 flush cleared", {31'd0, flush_o}, 32'd0);

    run_cmd(16'h0020, 16'h3300, 32'h0000_2000, 32'h0);
    check("R3 in last dir/last", {30'd0, req_write_o, req_last_o}, 32'd1);
    complete(16'h0003, 32'h0);
    check("R9 ptr", cmd_ptr_o, 32'h0001_2370);

    run_cmd(16'h0010, 16'h2000, 32'h0, 32'h0);
    expect_kill("R4 zero address", 32'h0001_2370);
    check("R13 run low clears dead", {31'd0, dead_o}, 32'd0);
    run_cmd(16'h0010, 16'h0400, 32'h0000_1000, 32'h0);
    expect_kill("R4 key 4", 32'h0001_2370);
    run_cmd(16'h0010, 16'h2700, 32'h0000_0500, 32'h0);
    expect_kill("R4 key 7", 32'h0001_2370);

    flush();
    run_cmd(16'h0007, 16'h4000, 32'h0000_2003, 32'h1122_3344);
    check("R6 key 0 word accepted", {30'd0, xfer_req_o, word_req_o}, 32'd1);
    check("R5 store len", {16'd0, req_len_o}, 32'd4);
    check("R5 store addr", req_addr_o, 32'h0000_2000);
    check("R5 store dir", {31'd0, req_write_o}, 32'd1);
    check("R5 store data", req_data_o, 32'h1122_3344);
    complete(16'hFFFF, 32'h0);
    check("R9 word residual", {16'd0, wb_res_o}, 32'd0);
    check("R9 store dep", wb_dep_o, 32'h1122_3344);
    check("R10 word clears flush", {31'd0, flush_o}, 32'd0);

    run_cmd(16'h0002, 16'h5600, 32'h0000_3003, 32'h0);
    check("R5 load len 2", {16'd0, req_len_o}, 32'd2);
    check("R5 load addr 2", req_addr_o, 32'h0000_3002);
    check("R5 load dir", {31'd0, req_write_o}, 32'd0);
    complete(16'h0, 32'hCAFE_F00D);
    check("R9 load dep", wb_dep_o, 32'hCAFE_F00D);
    check("R9 ptr", cmd_ptr_o, 32'h0001_2390);

    run_cmd(16'h0000, 16'h5600, 32'h0000_3003, 32'h0);
    check("R5 len 1", {16'd0, req_len_o}, 32'd1);
    check("R5 addr kept", req_addr_o, 32'h0000_3003);
    complete(16'h0, 32'h0);
    run_cmd(16'h0003, 16'h4200, 32'h0000_4001, 32'h0);
    check("R6 key 2 word", {30'd0, xfer_req_o, word_req_o}, 32'd1);
    check("R5 len from bit1", {16'd0, req_len_o}, 32'd2);
    check("R5 addr bit0", req_addr_o, 32'h0000_4000);
    complete(16'h0, 32'h0);

    run_cmd(16'h0004, 16'h5500, 32'h0000_3000, 32'h0);
    expect_kill("R6 key 5", 32'h0001_23B0);
    run_cmd(16'h0004, 16'h4400, 32'h0000_3000, 32'h0);
    expect_kill("R6 key 4", 32'h0001_23B0);

    flush();
    run_cmd(16'h0, 16'h6400, 32'h0, 32'h0000_00AA);
    check("R11 nop wb", {29'd0, wb_valid_o, xfer_req_o, word_req_o}, 32'd4);
    check("R11 nop ptr", cmd_ptr_o, 32'h0001_23C0);
    check("R11 nop no kill", {31'd0, dead_o}, 32'd0);
    check("R10 nop keeps flush", {31'd0, flush_o}, 32'd1);

    run_cmd(16'h0, 16'h7000, 32'h0, 32'h0);
    check("R8 stop inactive", {31'd0, active_o}, 32'd0);
    check("R8 stop ptr", cmd_ptr_o, 32'h0001_23C0);
    check("R8 stop no wb", {31'd0, wb_valid_o}, 32'd0);
    wake(); tick();
    check("R8 stop re-executed", {31'd0, active_o}, 32'd0);

    send_desc(16'h0004, 16'h0000, 32'h0000_6000, 32'h0);
    saw = 1'b0;
    for (int i = 0; i < 4; i++) begin tick(); saw = saw | xfer_req_o | word_req_o; end
    check("R2 no dispatch while inactive", {31'd0, saw}, 32'd0);
    wake(); tick();
    check("R2 dispatch after wake", {31'd0, xfer_req_o}, 32'd1);
    check("R2 held addr", req_addr_o, 32'h0000_6000);
    tick();
    check("R2 strobe one cycle", {31'd0, xfer_req_o}, 32'd0);
    complete(16'h0, 32'h0);
    check("R9 ptr", cmd_ptr_o, 32'h0001_23D0);

    run_cmd(16'h0, 16'h9000, 32'h0000_0100, 32'h0);
    expect_kill("R7 code 9", 32'h0001_23D0);

    tick(); tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule